// File: doc/BRIEF.md
# Software Command Address-Sequence Detector

This block sits on the asynchronous SRAM bus of a nonvolatile-backed memory and watches for a fixed run of read accesses that acts as a software command. Five prefix reads from fixed addresses followed by a sixth read select one of two commands. One selects a save of the SRAM contents into the nonvolatile array. The other selects a reload of the SRAM from that array. When the run completes, the block raises a one-clock request toward the controller. The controller then starts the cycle and holds the busy input high while the device is disabled.

The bus strobes are active low and asynchronous to the block clock, so they pass through a synchronizer first. An access is counted when it ends. That is the rising edge of chip-enable, or the rising edge of output-enable or write-enable while chip-enable stays low. The address is sampled at that moment, through a pipeline that matches the strobe synchronizer. Any write, or any read from an address off the key, discards the partial match. The key addresses, their order and the synchronizer depth are parameters or package constants.

Top module: `swcmd_seq_detect`

## Requirements
- R1: After reset, store_req_o and recall_req_o are low and the matcher is idle.
- R2: Six read accesses from 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 in that order, with nothing in between, produce exactly one store_req_o pulse that is one clock wide.
- R3: The same five prefix reads followed by a read from 0x0C63 produce exactly one recall_req_o pulse that is one clock wide.
- R4: A read from any address other than the expected next key address aborts the sequence. This includes a wrong sixth address. No request results from the remaining steps.
- R5: A write access never advances the sequence, even to the expected key address, and it aborts any partial match.
- R6: With chip-enable held low, each rising edge of output-enable counts as one read access and can mark a step.
- R7: With output-enable held high, each rising edge of chip-enable counts as one read access and can mark a step.
- R8: An aborting read from 0x0E38 restarts the match as if the first step had just been taken.
- R9: While busy_i is high, accesses are ignored, no request is issued and the matcher is forced to idle. A sequence interrupted by busy cannot complete afterwards.
- R10: store_req_o and recall_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 15 | SRAM bus address |
| ce_ni | input | 1 | Chip-enable, active low, asynchronous |
| oe_ni | input | 1 | Output-enable, active low, asynchronous |
| we_ni | input | 1 | Write-enable, active low, asynchronous |
| busy_i | input | 1 | Controller busy / device disabled |
| store_req_o | output | 1 | One-clock save-to-nonvolatile request |
| recall_req_o | output | 1 | One-clock reload-from-nonvolatile request |

## Verification
Some properties are checked on every cycle:
- The two requests are mutually exclusive.
- Each request lasts one clock.
- A request follows only a counted read, never a write.
- The matcher state stays in range.
- Busy forces the matcher to idle and blocks any request.

Other behaviour can only be shown by the bench's scenarios:
- The exact key order, the choice between store and recall by the sixth address, and the abort on a wrong or write access.
- The restart on 0x0E38.
- The equivalence of chip-enable-controlled and output-enable-controlled steps.

The bench compares every pulse against a queue of expected commands. It reports any pulse that no scenario expected.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;
  localparam int ADDR_W     = 15;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [ADDR_W-1:0] STORE_ADDR  = 15'h0FC0;
  localparam logic [ADDR_W-1:0] RECALL_ADDR = 15'h0C63;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  function automatic logic [ADDR_W-1:0] prefix_addr(input int unsigned idx);
    case (idx)
      0:       return 15'h0E38;
      1:       return 15'h31C7;
      2:       return 15'h03E0;
      3:       return 15'h3C1F;
      default: return 15'h303F;
    endcase
  endfunction
endpackage

// File: rtl/swcmd_sync.sv
module swcmd_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/swcmd_access_detect.sv
module swcmd_access_detect #(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_s_i,
  input  logic              oe_n_s_i,
  input  logic              we_n_s_i,
  input  logic [ADDR_W-1:0] addr_s_i,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  logic ce_q, oe_q, we_q, wr_flag_q;
  logic ce_rise, oe_rise, we_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b1;
      oe_q      <= 1'b1;
      we_q      <= 1'b1;
      wr_flag_q <= 1'b0;
    end else begin
      ce_q      <= ce_n_s_i;
      oe_q      <= oe_n_s_i;
      we_q      <= we_n_s_i;
      wr_flag_q <= acc_valid_o ? 1'b0 : (wr_flag_q | (~ce_n_s_i & ~we_n_s_i));
    end
  end

  // access ends on deassertion of its controlling strobe
  assign ce_rise = ce_n_s_i & ~ce_q;
  assign oe_rise = ~ce_n_s_i & ~ce_q & oe_n_s_i & ~oe_q;
  assign we_rise = ~ce_n_s_i & ~ce_q & we_n_s_i & ~we_q;

  assign acc_valid_o = ce_rise | oe_rise | we_rise;
  assign acc_write_o = wr_flag_q | (~ce_q & ~we_q);
  assign acc_addr_o  = addr_s_i;
endmodule

// File: rtl/swcmd_key_matcher.sv
module swcmd_key_matcher
  import swcmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic [STEP_W-1:0] step_o,
  output logic              store_o,
  output logic              recall_o
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              store_d, recall_d, store_q, recall_q;
  logic              hit_first;

  assign hit_first = (acc_addr_i == prefix_addr(0));

  always_comb begin
    step_d   = step_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (busy_i) begin
      step_d = '0;
    end else if (acc_valid_i) begin
      if (acc_write_i) begin
        step_d = '0;
      end else if (step_q < STEP_W'(PREFIX_LEN)) begin
        if (acc_addr_i == prefix_addr(32'(step_q))) step_d = step_q + 1'b1;
        else                                         step_d = hit_first ? STEP_W'(1) : '0;
      end else begin
        step_d = hit_first ? STEP_W'(1) : '0;
        if (acc_addr_i == STORE_ADDR) begin
          store_d = 1'b1;
          step_d  = '0;
        end else if (acc_addr_i == RECALL_ADDR) begin
          recall_d = 1'b1;
          step_d   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      store_q  <= store_d;
      recall_q <= recall_d;
    end
  end

  assign step_o   = step_q;
  assign store_o  = store_q;
  assign recall_o = recall_q;
endmodule

// File: rtl/swcmd_seq_detect.sv
module swcmd_seq_detect
  import swcmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              busy_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  localparam int BUS_W = ADDR_W + 3;

  logic [BUS_W-1:0]  bus_s;
  logic              acc_valid, acc_write;
  logic [ADDR_W-1:0] acc_addr;
  logic [STEP_W-1:0] step;

  // address travels with the strobes so it is sampled at the same point
  swcmd_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({{ADDR_W{1'b0}}, 3'b111})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, ce_ni, oe_ni, we_ni}),
    .q_o   (bus_s)
  );

  swcmd_access_detect #(.ADDR_W(ADDR_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_n_s_i   (bus_s[2]),
    .oe_n_s_i   (bus_s[1]),
    .we_n_s_i   (bus_s[0]),
    .addr_s_i   (bus_s[BUS_W-1:3]),
    .acc_valid_o(acc_valid),
    .acc_write_o(acc_write),
    .acc_addr_o (acc_addr)
  );

  swcmd_key_matcher u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_i),
    .acc_valid_i(acc_valid),
    .acc_write_i(acc_write),
    .acc_addr_i (acc_addr),
    .step_o     (step),
    .store_o    (store_req_o),
    .recall_o   (recall_req_o)
  );
endmodule

// File: rtl/swcmd_seq_detect_chk.sv
module swcmd_seq_detect_chk
  import swcmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [STEP_W-1:0] step,
  input logic              store_req_o,
  input logic              recall_req_o
);
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_req_o && recall_req_o));

  a_r2_store_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);

  a_r3_recall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);

  // R5: a request only follows a counted read
  a_r5_req_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(store_req_o | recall_req_o) |-> $past(acc_valid && !acc_write));

  a_r9_busy_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (step == '0) && !store_req_o && !recall_req_o);

  a_r4_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step <= STEP_W'(PREFIX_LEN));

  // R1: idle after reset
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (!store_req_o && !recall_req_o && step == '0);
  end
endmodule

bind swcmd_seq_detect swcmd_seq_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .step        (step),
  .store_req_o (store_req_o),
  .recall_req_o(recall_req_o)
);

// File: tb/swcmd_seq_detect_tb_top.sv
module swcmd_seq_detect_tb_top;
  import swcmd_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic              store_req, recall_req;

  int    checks = 0, failures = 0;
  cmd_e  exp_q[$];
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  swcmd_seq_detect dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .addr_i      (addr),
    .ce_ni       (ce_n),
    .oe_ni       (oe_n),
    .we_ni       (we_n),
    .busy_i      (busy),
    .store_req_o (store_req),
    .recall_req_o(recall_req)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // CE-controlled read, OE left high (R7)
  task automatic rd_ce(input logic [ADDR_W-1:0] a);
    addr = a; ce_n = 1'b0; cycles(3);
    ce_n = 1'b1; cycles(4);
  endtask

  // OE-controlled read with CE already low (R6)
  task automatic rd_oe(input logic [ADDR_W-1:0] a);
    addr = a; oe_n = 1'b0; cycles(3);
    oe_n = 1'b1; cycles(4);
  endtask

  task automatic wr_ce(input logic [ADDR_W-1:0] a);
    addr = a; ce_n = 1'b0; we_n = 1'b0; cycles(3);
    ce_n = 1'b1; we_n = 1'b1; cycles(4);
  endtask

  task automatic prefix_ce();
    for (int i = 0; i < PREFIX_LEN; i++) rd_ce(prefix_addr(i));
  endtask

  task automatic expect_cmd(input cmd_e c);
    exp_q.push_back(c);
  endtask

  task automatic drain(input string req);
    cycles(8);
    check(exp_q.size() == 0, req, "pending expected pulses", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: pops expected commands as pulses appear
  logic prev_st = 1'b0, prev_rc = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (store_req && recall_req)
        check(1'b0, "R10", "both requests high", 1, 0);
      if ((store_req && prev_st) || (recall_req && prev_rc))
        check(1'b0, "R10", "request wider than one clock", 2, 1);
      if ((store_req && !prev_st) || (recall_req && !prev_rc)) begin
        cmd_e got;
        got = store_req ? CMD_STORE : CMD_RECALL;
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected request", int'(got), int'(CMD_NONE));
        end else begin
          cmd_e want;
          want = exp_q.pop_front();
          check(got == want, cur_req, "request kind", int'(got), int'(want));
        end
      end
    end
    prev_st = store_req;
    prev_rc = recall_req;
  end

  initial begin
    cycles(3);
    check(store_req == 1'b0, "R1", "store after reset", int'(store_req), 0);
    check(recall_req == 1'b0, "R1", "recall after reset", int'(recall_req), 0);
    rst_ni = 1'b1;
    cycles(4);
    check(!store_req && !recall_req, "R1", "idle after release", int'({store_req, recall_req}), 0);

    cur_req = "R2"; expect_cmd(CMD_STORE);
    prefix_ce(); rd_ce(STORE_ADDR); drain("R2");

    cur_req = "R3"; expect_cmd(CMD_RECALL);
    prefix_ce(); rd_ce(RECALL_ADDR); drain("R3");

    cur_req = "R6"; expect_cmd(CMD_STORE);
    ce_n = 1'b0; cycles(2);
    for (int i = 0; i < PREFIX_LEN; i++) rd_oe(prefix_addr(i));
    rd_oe(STORE_ADDR);
    ce_n = 1'b1; drain("R6");

    cur_req = "R6"; expect_cmd(CMD_RECALL);
    ce_n = 1'b0; cycles(2);
    for (int i = 0; i < PREFIX_LEN; i++) rd_oe(prefix_addr(i));
    rd_oe(RECALL_ADDR);
    ce_n = 1'b1; drain("R6");

    // R7: mixed, CE-controlled steps with OE high already covered; repeat after aborts
    cur_req = "R4";
    rd_ce(prefix_addr(0)); rd_ce(prefix_addr(1)); rd_ce(15'h1234);
    rd_ce(prefix_addr(3)); rd_ce(prefix_addr(4)); rd_ce(STORE_ADDR);
    drain("R4");
    prefix_ce(); rd_ce(15'h0FC1); drain("R4");
    prefix_ce(); rd_ce(prefix_addr(1)); rd_ce(RECALL_ADDR); drain("R4");

    cur_req = "R7"; expect_cmd(CMD_STORE);
    prefix_ce(); rd_ce(STORE_ADDR); drain("R7");

    cur_req = "R5";
    rd_ce(prefix_addr(0)); rd_ce(prefix_addr(1)); wr_ce(prefix_addr(2));
    rd_ce(prefix_addr(3)); rd_ce(prefix_addr(4)); rd_ce(STORE_ADDR);
    drain("R5");
    rd_ce(prefix_addr(0)); rd_ce(prefix_addr(1)); wr_ce(prefix_addr(2));
    rd_ce(prefix_addr(2)); rd_ce(prefix_addr(3)); rd_ce(prefix_addr(4)); rd_ce(RECALL_ADDR);
    drain("R5");
    prefix_ce(); wr_ce(STORE_ADDR); drain("R5");

    cur_req = "R8"; expect_cmd(CMD_STORE);
    rd_ce(prefix_addr(0)); rd_ce(prefix_addr(1)); rd_ce(prefix_addr(2));
    rd_ce(prefix_addr(0));
    for (int i = 1; i < PREFIX_LEN; i++) rd_ce(prefix_addr(i));
    rd_ce(STORE_ADDR); drain("R8");

    cur_req = "R8"; expect_cmd(CMD_RECALL);
    prefix_ce(); rd_ce(prefix_addr(0));
    for (int i = 1; i < PREFIX_LEN; i++) rd_ce(prefix_addr(i));
    rd_ce(RECALL_ADDR); drain("R8");

    cur_req = "R9";
    rd_ce(prefix_addr(0)); rd_ce(prefix_addr(1)); rd_ce(prefix_addr(2));
    busy = 1'b1; cycles(2); rd_ce(prefix_addr(3)); busy = 1'b0; cycles(2);
    rd_ce(prefix_addr(3)); rd_ce(prefix_addr(4)); rd_ce(STORE_ADDR);
    drain("R9");
    busy = 1'b1; prefix_ce(); rd_ce(RECALL_ADDR); cycles(2); busy = 1'b0;
    drain("R9");
    prefix_ce(); busy = 1'b1; rd_ce(STORE_ADDR); busy = 1'b0; drain("R9");
    expect_cmd(CMD_RECALL); prefix_ce(); rd_ce(RECALL_ADDR); drain("R9");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule